// File: doc/BRIEF.md
# Receive Elastic Store with Whole-Frame Slip

This block sits on the receive side of a 2.048 Mbit/s framed link. It sits between the clock recovered from the line and the local system clock. Each frame holds 32 byte-wide timeslots. Bytes arrive in the line clock domain together with their timeslot number. The block stores each byte at an address built from that timeslot number and a frame counter. The system side reads the bytes out one per read strobe, in step with its own local frame. Each byte comes out with its timeslot number and a start-of-frame flag.

The two clocks drift apart by a small amount, so the number of stored bytes changes slowly. The write pointer crosses into the read domain in Gray code. There the block measures the fill, but only on the last timeslot of each local frame. If the fill is above three quarters of the buffer, the next stored frame is skipped. If it is below one quarter, the frame just read is replayed. Either way, a whole frame of 32 bytes is removed or repeated, so the timeslot order seen downstream is never broken. Each slip is reported by a one-cycle pulse: one pulse for deletions and another for repeats. A saturating counter totals the slips of both kinds.

The buffer depth is a power-of-two number of frames (2, 4 or 8). The line side is assumed to present timeslots in sequence, 0 to 31 and round again.

Top module: `e1_elastic_store`

## Requirements
- R1: While `rd_rst_n` is low, `rd_data`, `rd_slot`, `rd_sof`, `slip_del`, `slip_rep` and `slip_count` are all zero at the next clock. After both resets are released, the read pointer sits half the buffer behind the write pointer. So the byte taken at the first write after reset comes out as read byte number FRAMES*16, counting the first read after reset as number 0.
- R2: Each read strobe advances `rd_slot` by one, modulo 32, starting from 0 after reset. `rd_sof` is 1 exactly when `rd_slot` is 0. A byte written with timeslot s is always read out with `rd_slot` equal to s.
- R3: While the fill stays between a quarter and three quarters of the depth, frames come out in the order they were written, and no slip pulse is raised.
- R4: The fill is taken just after the last byte of a read frame. It counts the bytes written but not yet read. If it is greater than 3/4 of the depth, the next stored frame is skipped, so the frame that follows is two frames later in write order. `slip_del` pulses in that case.
- R5: If that fill is less than 1/4 of the depth, the frame just read is read again in full, and `slip_rep` pulses.
- R6: A slip pulse is high only in the cycle where `rd_slot` shows 31. The read position changes only between timeslot 31 and timeslot 0.
- R7: `slip_count` rises by exactly one on each slip pulse of either kind and holds otherwise. It stops at its all-ones value and does not wrap.
- R8: `slip_del` and `slip_rep` are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Clock recovered from the line |
| wr_rst_n | input | 1 | Synchronous active-low reset, line domain |
| wr_valid | input | 1 | Strobe: one received byte present |
| wr_slot | input | 5 | Timeslot number of the received byte |
| wr_data | input | 8 | Received byte |
| rd_clk | input | 1 | Local system clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, system domain |
| rd_en | input | 1 | Read strobe: take the next byte of the local frame |
| rd_data | output | 8 | Byte read out |
| rd_slot | output | 5 | Local timeslot number of `rd_data` |
| rd_sof | output | 1 | High with timeslot 0 of each local frame |
| slip_del | output | 1 | One-cycle pulse: one frame deleted |
| slip_rep | output | 1 | One-cycle pulse: one frame repeated |
| slip_count | output | CNT_W | Saturating total of slips |

## Verification
The bench builds the store with a two-frame depth, so the thresholds sit at 16 and 48 bytes. With this depth, a delete or a repeat happens after only a few frames of clock mismatch. The line clock is run equal to, about 14% faster than, and about 11% slower than the system clock. This exaggerates real drift so that many slips of each kind happen in a short run. The count width is set to 3 bits, so those runs push the counter past its limit of 7 and the saturation case is exercised. Every byte carries a frame tag and its own timeslot number. This lets each skip, replay and the reset offset be checked from the output bytes alone.

// File: rtl/e1es_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the receive elastic store.
// Assumes a frame of 32 byte-wide timeslots.
package e1es_pkg;
    localparam int SLOTS  = 32;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BYTE_W = 8;

    // Action taken by the read side when a local frame ends
    typedef enum logic [1:0] {
        ACT_STEP   = 2'd0,
        ACT_DELETE = 2'd1,
        ACT_REPEAT = 2'd2
    } frame_act_e;
endpackage

// File: rtl/e1es_ram.sv
`timescale 1ns/1ps
// Two-clock storage for the elastic store.
// Write port runs on the line clock. Read port runs on the system clock,
// with a registered output that loads only on a read strobe.
// Assumes one write and one read per cycle at most, no read-during-write care.
module e1es_ram
    import e1es_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [BYTE_W-1:0] mem [WORDS];

    // Store one received byte
    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read toward the system side
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/e1es_wr_ctrl.sv
`timescale 1ns/1ps
// Line-side addressing for the elastic store.
// The storage address is the local frame counter joined to the incoming
// timeslot number. The byte pointer advances once per stored byte, and a
// Gray copy of it is registered for the crossing to the system clock.
// Assumes timeslots arrive in order, so the pointer moves by one per write.
module e1es_wr_ctrl
    import e1es_pkg::*;
#(
    parameter int FRAMES = 4,
    parameter int AW     = $clog2(FRAMES * SLOTS),
    parameter int PW     = AW + 1
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_valid,
    input  logic [SLOT_W-1:0] wr_slot,
    output logic              ram_we,
    output logic [AW-1:0]     ram_waddr,
    output logic [PW-1:0]     wptr_gray
);
    localparam int            DEPTH     = FRAMES * SLOTS;
    localparam logic [PW-1:0] HALF      = PW'(DEPTH / 2);
    localparam logic [PW-1:0] HALF_GRAY = HALF ^ (HALF >> 1);

    logic [PW-1:0] wptr;
    logic [PW-1:0] wptr_nxt;

    // Address and next pointer from frame counter plus incoming timeslot
    always_comb begin
        ram_we    = wr_valid;
        ram_waddr = {wptr[AW-1:SLOT_W], wr_slot};
        wptr_nxt  = {wptr[PW-1:SLOT_W], wr_slot} + PW'(1);
    end

    // Pointer and its Gray image; reset leaves the writer half a buffer ahead
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wptr      <= HALF;
            wptr_gray <= HALF_GRAY;
        end else if (wr_valid) begin
            wptr      <= wptr_nxt;
            wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end
endmodule

// File: rtl/e1es_gray_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray-coded pointer, followed by a Gray to
// binary conversion in the receiving domain.
// Assumes the source changes at most one bit per source clock.
module e1es_gray_sync #(
    parameter int          PW       = 8,
    parameter logic [PW-1:0] RST_GRAY = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] meta_q;
    logic [PW-1:0] sync_q;

    // Two-stage capture into the receiving clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_GRAY;
            sync_q <= RST_GRAY;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    // Gray to binary: each bit is the XOR of all higher Gray bits
    always_comb begin
        bin_out[PW-1] = sync_q[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ sync_q[i];
        end
    end
endmodule

// File: rtl/e1es_rd_ctrl.sv
`timescale 1ns/1ps
// System-side reader for the elastic store.
// It walks the local frame one timeslot per read strobe. On the last
// timeslot it compares the fill against the quarter and three-quarter
// marks, and moves the read pointer on by zero, one or two frames.
// It also produces the slip pulses and the saturating slip total.
// Assumes the buffer depth is a power of two bytes.
module e1es_rd_ctrl
    import e1es_pkg::*;
#(
    parameter int FRAMES = 4,
    parameter int CNT_W  = 8,
    parameter int AW     = $clog2(FRAMES * SLOTS),
    parameter int PW     = AW + 1
) (
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic [PW-1:0]     wptr_bin,
    output logic              ram_re,
    output logic [AW-1:0]     ram_raddr,
    output logic [SLOT_W-1:0] rd_slot,
    output logic              rd_sof,
    output logic              slip_del,
    output logic              slip_rep,
    output logic [CNT_W-1:0]  slip_count
);
    localparam int               DEPTH   = FRAMES * SLOTS;
    localparam logic [PW-1:0]    HI_LVL  = PW'((3 * DEPTH) / 4);
    localparam logic [PW-1:0]    LO_LVL  = PW'(DEPTH / 4);
    localparam logic [PW-1:0]    FRM_SZ  = PW'(SLOTS);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [PW-1:0] rptr;
    logic [PW-1:0] step_ptr;
    logic [PW-1:0] fill;
    logic [PW-1:0] target;
    logic          frame_end;
    frame_act_e    act;

    // Fill and slip decision, taken only at the last timeslot
    always_comb begin
        frame_end = (rptr[SLOT_W-1:0] == SLOT_W'(SLOTS - 1));
        step_ptr  = rptr + PW'(1);
        fill      = wptr_bin - step_ptr;
        if (!frame_end) begin
            act = ACT_STEP;
        end else if (fill > HI_LVL) begin
            act = ACT_DELETE;
        end else if (fill < LO_LVL) begin
            act = ACT_REPEAT;
        end else begin
            act = ACT_STEP;
        end
        case (act)
            ACT_DELETE: target = step_ptr + FRM_SZ;
            ACT_REPEAT: target = step_ptr - FRM_SZ;
            default:    target = step_ptr;
        endcase
        ram_re    = rd_en;
        ram_raddr = rptr[AW-1:0];
    end

    // Read pointer advance
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rptr <= '0;
        end else if (rd_en) begin
            rptr <= target;
        end
    end

    // Timeslot label and frame marker, aligned with the registered data
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_slot <= '0;
            rd_sof  <= 1'b0;
        end else if (rd_en) begin
            rd_slot <= rptr[SLOT_W-1:0];
            rd_sof  <= (rptr[SLOT_W-1:0] == '0);
        end
    end

    // One-cycle slip pulses
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            slip_del <= 1'b0;
            slip_rep <= 1'b0;
        end else begin
            slip_del <= rd_en && (act == ACT_DELETE);
            slip_rep <= rd_en && (act == ACT_REPEAT);
        end
    end

    // Saturating slip total
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            slip_count <= '0;
        end else if (rd_en && (act != ACT_STEP) && (slip_count != CNT_MAX)) begin
            slip_count <= slip_count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/e1_elastic_store.sv
`timescale 1ns/1ps
// Receive elastic store with whole-frame slip.
// Line bytes are stored by frame and timeslot. They are read out aligned to
// the local frame, and whole frames are deleted or repeated to hold the fill
// near half. Only the write pointer crosses domains, in Gray code.
// Assumes FRAMES is 2, 4 or 8 and that line timeslots arrive in sequence.
module e1_elastic_store
    import e1es_pkg::*;
#(
    parameter int FRAMES = 4,
    parameter int CNT_W  = 8
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_valid,
    input  logic [4:0]        wr_slot,
    input  logic [7:0]        wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    output logic [4:0]        rd_slot,
    output logic              rd_sof,
    output logic              slip_del,
    output logic              slip_rep,
    output logic [CNT_W-1:0]  slip_count
);
    localparam int            DEPTH     = FRAMES * SLOTS;
    localparam int            AW        = $clog2(DEPTH);
    localparam int            PW        = AW + 1;
    localparam logic [PW-1:0] HALF      = PW'(DEPTH / 2);
    localparam logic [PW-1:0] HALF_GRAY = HALF ^ (HALF >> 1);

    logic          ram_we;
    logic [AW-1:0] ram_waddr;
    logic          ram_re;
    logic [AW-1:0] ram_raddr;
    logic [PW-1:0] wptr_gray;
    logic [PW-1:0] wptr_bin;

    e1es_wr_ctrl #(
        .FRAMES (FRAMES),
        .AW     (AW),
        .PW     (PW)
    ) u_wr_ctrl (
        .wr_clk    (wr_clk),
        .wr_rst_n  (wr_rst_n),
        .wr_valid  (wr_valid),
        .wr_slot   (wr_slot),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .wptr_gray (wptr_gray)
    );

    e1es_gray_sync #(
        .PW       (PW),
        .RST_GRAY (HALF_GRAY)
    ) u_wptr_sync (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .gray_in (wptr_gray),
        .bin_out (wptr_bin)
    );

    e1es_ram #(
        .AW (AW)
    ) u_ram (
        .wr_clk   (wr_clk),
        .we       (ram_we),
        .waddr    (ram_waddr),
        .wdata    (wr_data),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .re       (ram_re),
        .raddr    (ram_raddr),
        .rdata    (rd_data)
    );

    e1es_rd_ctrl #(
        .FRAMES (FRAMES),
        .CNT_W  (CNT_W),
        .AW     (AW),
        .PW     (PW)
    ) u_rd_ctrl (
        .rd_clk     (rd_clk),
        .rd_rst_n   (rd_rst_n),
        .rd_en      (rd_en),
        .wptr_bin   (wptr_bin),
        .ram_re     (ram_re),
        .ram_raddr  (ram_raddr),
        .rd_slot    (rd_slot),
        .rd_sof     (rd_sof),
        .slip_del   (slip_del),
        .slip_rep   (slip_rep),
        .slip_count (slip_count)
    );
endmodule

// File: rtl/e1es_checker.sv
`timescale 1ns/1ps
// Property checker for the elastic store's system-side outputs.
// Bound to every instance of the top module.
module e1es_checker #(
    parameter int CNT_W = 8
) (
    input logic             rd_clk,
    input logic             rd_rst_n,
    input logic             rd_en,
    input logic [4:0]       rd_slot,
    input logic             slip_del,
    input logic             slip_rep,
    input logic [CNT_W-1:0] slip_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R8: the two slip kinds never coincide
    assert_slip_exclusive_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !(slip_del && slip_rep));

    // R8: a slip pulse lasts a single cycle
    assert_slip_single_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (slip_del || slip_rep) |=> !(slip_del || slip_rep));

    // R6: slips appear only with the last timeslot of a local frame
    assert_slip_at_boundary_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (slip_del || slip_rep) |-> (rd_slot == 5'd31));

    // R2: consecutive reads label consecutive timeslots
    assert_slot_advance_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && $past(rd_en) && $past(rd_rst_n)) |=> (rd_slot == 5'($past(rd_slot) + 5'd1)));

    // R7: each slip adds one unless the total is already at its limit
    assert_count_step_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (slip_del || slip_rep) |->
            ((slip_count == CNT_W'($past(slip_count) + CNT_W'(1))) ||
             (($past(slip_count) == CNT_MAX) && (slip_count == CNT_MAX))));

    // R7: without a slip the total holds
    assert_count_hold_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!(slip_del || slip_rep) && $past(rd_rst_n)) |-> $stable(slip_count));
endmodule

bind e1_elastic_store e1es_checker #(.CNT_W(CNT_W)) u_e1es_chk (
    .rd_clk     (rd_clk),
    .rd_rst_n   (rd_rst_n),
    .rd_en      (rd_en),
    .rd_slot    (rd_slot),
    .slip_del   (slip_del),
    .slip_rep   (slip_rep),
    .slip_count (slip_count)
);

// File: tb/e1_elastic_store_test.sv
`timescale 1ns/1ps
// Directed bench: every line byte carries {frame_tag[2:0], timeslot[4:0]}.
module e1_elastic_store_test;
    localparam int FR     = 2;
    localparam int CW     = 3;
    localparam int SATMAX = 7;
    localparam int OFFSET = FR * 16;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0;
    logic          rd_rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [4:0]    wr_slot = '0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic [4:0]    rd_slot;
    logic          rd_sof;
    logic          slip_del;
    logic          slip_rep;
    logic [CW-1:0] slip_count;

    int  n_checks = 0;
    int  n_fail   = 0;
    real wr_half  = 4.0;
    bit  wr_run   = 1'b0;
    bit  mon_on   = 1'b0;
    int  idx, dels, reps, pend;
    logic [2:0] cur_tag;

    e1_elastic_store #(.FRAMES(FR), .CNT_W(CW)) uut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid),
        .wr_slot(wr_slot), .wr_data(wr_data), .rd_clk(rd_clk),
        .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
        .rd_slot(rd_slot), .rd_sof(rd_sof), .slip_del(slip_del),
        .slip_rep(slip_rep), .slip_count(slip_count)
    );

    initial forever #4 rd_clk = ~rd_clk;
    initial begin
        #1.3;
        forever #(wr_half) wr_clk = ~wr_clk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // Line-side source: sequential timeslots, frame tag counts frames
    initial begin
        logic [4:0] s;
        logic [2:0] f;
        s = '0;
        f = '0;
        forever begin
            @(negedge wr_clk);
            if (!wr_run) begin
                wr_valid = 1'b0;
                s = '0;
                f = '0;
            end else begin
                wr_valid = 1'b1;
                wr_slot  = s;
                wr_data  = {f, s};
                if (s == 5'd31) f = f + 3'd1;
                s = s + 5'd1;
            end
        end
    end

    // System-side monitor: one sample per read strobe
    initial begin
        bit armed;
        int es;
        logic [2:0] exp_tag;
        string tag_req;
        forever begin
            @(posedge rd_clk);
            armed = mon_on;
            @(negedge rd_clk);
            if (armed) begin
                es = idx % 32;
                check(rd_slot == 5'(es), "R2", "rd_slot", rd_slot, es);
                check(rd_sof == (es == 0), "R2", "rd_sof", rd_sof, es == 0);
                if (idx >= OFFSET) begin
                    check(rd_data[4:0] == 5'(es), "R2", "byte timeslot", rd_data[4:0], es);
                    if (es == 0) begin
                        if (idx == OFFSET) begin
                            exp_tag = 3'd0;
                            tag_req = "R1";
                        end else if (pend == 1) begin
                            exp_tag = cur_tag + 3'd2;
                            tag_req = "R4";
                        end else if (pend == 2) begin
                            exp_tag = cur_tag;
                            tag_req = "R5";
                        end else begin
                            exp_tag = cur_tag + 3'd1;
                            tag_req = "R3";
                        end
                        check(rd_data[7:5] == exp_tag, tag_req, "frame tag at frame start",
                              rd_data[7:5], exp_tag);
                        cur_tag = exp_tag;
                    end else begin
                        check(rd_data[7:5] == cur_tag, "R3", "frame tag inside frame",
                              rd_data[7:5], cur_tag);
                    end
                end
                if (es == 31) pend = slip_del ? 1 : (slip_rep ? 2 : 0);
                if (slip_del || slip_rep) begin
                    check(es == 31, "R6", "slip pulse timeslot", es, 31);
                    check(!(slip_del && slip_rep), "R8", "both pulses", 1, 0);
                end
                if (slip_del) dels++;
                if (slip_rep) reps++;
                check(int'(slip_count) == ((dels + reps > SATMAX) ? SATMAX : dels + reps),
                      "R7", "slip_count", slip_count,
                      (dels + reps > SATMAX) ? SATMAX : dels + reps);
                idx++;
            end
        end
    end

    // Reset both sides, then stream for n read strobes
    task automatic run_window(input real half, input int n);
        @(posedge rd_clk);
        #2;
        mon_on = 1'b0;
        wr_run = 1'b0;
        rd_en = 1'b0;
        rd_rst_n = 1'b0;
        wr_rst_n = 1'b0;
        wr_half = half;
        repeat (4) @(posedge rd_clk);
        #2;
        idx = 0; dels = 0; reps = 0; pend = 0; cur_tag = '0;
        rd_rst_n = 1'b1;
        wr_rst_n = 1'b1;
        rd_en = 1'b1;
        wr_run = 1'b1;
        mon_on = 1'b1;
        wait (idx >= n);
        mon_on = 1'b0;
    endtask

    // R1: outputs cleared while reset is held
    task automatic test_reset();
        rd_rst_n = 1'b0;
        wr_rst_n = 1'b0;
        rd_en = 1'b1;
        repeat (3) @(posedge rd_clk);
        @(negedge rd_clk);
        check(rd_data == 8'd0, "R1", "rd_data in reset", rd_data, 0);
        check(rd_slot == 5'd0, "R1", "rd_slot in reset", rd_slot, 0);
        check(rd_sof == 1'b0, "R1", "rd_sof in reset", rd_sof, 0);
        check(slip_del == 1'b0, "R1", "slip_del in reset", slip_del, 0);
        check(slip_rep == 1'b0, "R1", "slip_rep in reset", slip_rep, 0);
        check(slip_count == '0, "R1", "slip_count in reset", slip_count, 0);
        rd_en = 1'b0;
    endtask

    // R3: matched clocks, no slips at all
    task automatic test_matched();
        run_window(4.0, 1600);
        check(dels == 0, "R3", "deletes at matched rate", dels, 0);
        check(reps == 0, "R3", "repeats at matched rate", reps, 0);
        check(slip_count == '0, "R3", "count at matched rate", slip_count, 0);
    endtask

    // R4 and R7: faster line clock forces deletes past the counter limit
    task automatic test_fast_line();
        run_window(3.5, 3000);
        check(dels >= SATMAX + 1, "R4", "deletes with fast line", dels, SATMAX + 1);
        check(reps == 0, "R4", "no repeats with fast line", reps, 0);
        check(int'(slip_count) == SATMAX, "R7", "saturated count", slip_count, SATMAX);
    endtask

    // R5: slower line clock forces repeats
    task automatic test_slow_line();
        run_window(4.5, 3000);
        check(reps >= 5, "R5", "repeats with slow line", reps, 5);
        check(dels == 0, "R5", "no deletes with slow line", dels, 0);
    endtask

    initial begin
        #1ms;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog run did not complete actual=1 expected=0");
        finish_run();
    end

    initial begin
        test_reset();
        test_matched();
        test_fast_line();
        test_slow_line();
        finish_run();
    end
endmodule